// File: doc/BRIEF.md
# Minimum-Error Dithered Pulse-Width Encoder

This block converts a stream of digital envelope samples, one per fast source clock, into a one-bit pulse stream for a switching supply modulator. The period of each pulse is not fixed. While the current pulse plays out, the block searches every allowed period for the next pulse, one candidate per clock. For each candidate it finds the best high-time. It keeps the period and width pair whose duty ratio best matches the envelope value at the middle of that candidate pulse. The switching frequency therefore drifts with the signal, and the clock spurs are spread out.

The residual error of each chosen pair is added to the target of the following decision. This is first-order noise shaping. The set of allowed periods follows from a configured average bit count. The pulse output lags the envelope input by a fixed number of clocks. This lag gives the search a look-ahead window. A strobe marks the first clock of every pulse and carries that pulse's period and width.

Top module: `mqed_pwm`

## Requirements
- R1: With average bit count N on `nb` (sampled only while `rst` is high, N from 2 to 6), every pulse period M lies in 2^N - 2^(N-2) + 1 .. 2^N + 2^(N-2) - 1. That range is 49..79 for N=6 and 13..19 for N=4.
- R2: The output in clock t stands for the `env_in` sample presented in clock t-128, where clock 0 is the first clock after reset is released. Samples before clock 0 count as zero. For a candidate M starting at clock S, the envelope used is the one standing at clock S + floor(M/2).
- R3: Values are in units of 2^-16. The target is env*16 + fb, where fb is the fed-back error. The width is W = floor((M*target + 2^15) / 2^16), clamped to 0..M.
- R4: The ratio is W * floor((2^16 + floor(M/2)) / M), and the candidate error is e = target - ratio.
- R5: Every M in the range is scored separately, so equal ratios from different periods stay distinct. The pair with the smallest |e| is chosen, and on equal |e| the shorter period wins.
- R6: The e of the chosen pair becomes fb for the next decision. Reset sets fb to zero.
- R7: Each pulse is high for its first W clocks and low for the remaining M-W clocks.
- R8: `pulse_stb` is high for exactly the first clock of each pulse. `pulse_m` and `pulse_w` show that pulse's M and W and hold through the whole pulse.
- R9: After reset, `pwm_out` and `pulse_stb` stay low for the first 2^N - 2^(N-2) + 1 clocks. The first pulse begins at that clock.
- R10: A pulse with W=0 still raises the strobe but keeps the output low. Pulses with W=M keep the output high across the pulse boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous active-high reset |
| env_in | input | 12 | Envelope sample, unsigned fraction of full scale |
| nb | input | 3 | Average bit count, sampled during reset |
| pwm_out | output | 1 | Serial pulse stream |
| pulse_stb | output | 1 | High in the first clock of each pulse |
| pulse_m | output | 7 | Period of the current pulse in clocks |
| pulse_w | output | 7 | High-time of the current pulse in clocks |

## Verification
The bench goes after three kinds of error: the centre-sample alignment, the tie rule and the clamped widths. A zero envelope makes every candidate score zero error, so a design that broke ties toward the longer period, or that merged pairs by ratio, would report 79 instead of 49. A full-scale envelope pushes W to M. An off-by-one clamp would then show a one-clock dip at every boundary, or a width above the period. Varying envelopes at both bit counts expose a tap that is off by one or two samples, or feedback that is dropped or has the wrong sign, because these lead to a different chosen period within a few pulses. A mid-run reset shows whether the feedback and the start-up quiet interval really restart.

// File: rtl/mqed_pwm.sv
module mqed_pwm #(
  parameter int ENV_W  = 12,
  parameter int FRAC   = 16,
  parameter int NB_MAX = 6,
  parameter int EW     = 22,
  localparam int MAXP  = 2**NB_MAX + 2**(NB_MAX-2) - 1,
  localparam int PW    = $clog2(MAXP + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [ENV_W-1:0] env_in,
  input  logic [2:0]       nb,
  output logic             pwm_out,
  output logic             pulse_stb,
  output logic [PW-1:0]    pulse_m,
  output logic [PW-1:0]    pulse_w
);
  localparam int AW    = $clog2(MAXP + MAXP/2 + 2);
  localparam int DEPTH = 2**AW;
  localparam int LAT   = DEPTH;
  localparam int PRW   = EW + PW + 1;

  function automatic logic [PW-1:0] lo_of(input logic [2:0] n);
    int k;
    k = int'(n);
    return PW'((1 << k) - (1 << (k - 2)) + 1);
  endfunction

  logic [ENV_W-1:0]     sr [DEPTH];
  logic [FRAC:0]        rtab [2**PW];
  logic [2:0]           nbq;
  logic [PW-1:0]        cnt, cur_m, cur_w, best_m, best_w;
  logic                 run;
  logic signed [EW-1:0] fb, best_e;
  logic [EW-1:0]        best_mag;

  logic [PW-1:0]        ncand, cand_m, w_c;
  logic                 searching;
  logic [AW-1:0]        jsel;
  logic [ENV_W-1:0]     env_c;
  logic signed [EW-1:0] tgt, e_c;
  logic signed [PRW-1:0] prod, wr;
  logic [EW-1:0]        ratio, mag;

  for (genvar g = 0; g < 2**PW; g++) begin : g_recip
    assign rtab[g] = (FRAC+1)'((2**FRAC + g/2) / (g == 0 ? 1 : g));
  end

  assign ncand     = PW'((1 << (int'(nbq) - 1)) - 1);
  assign searching = cnt < ncand;
  assign cand_m    = lo_of(nbq) + cnt;
  assign jsel      = AW'(LAT - int'(cur_m) - int'(cand_m >> 1) + int'(cnt) - 1);
  assign env_c     = sr[jsel];

  assign tgt  = $signed(EW'({env_c, {(FRAC-ENV_W){1'b0}}})) + fb;
  assign prod = $signed({1'b0, cand_m}) * tgt;
  assign wr   = (prod + $signed(PRW'(2**(FRAC-1)))) >>> FRAC;

  always_comb begin
    if (wr < 0)
      w_c = '0;
    else if (wr > $signed({{(EW+1){1'b0}}, cand_m}))
      w_c = cand_m;
    else
      w_c = PW'(wr);
  end

  assign ratio = EW'(w_c) * EW'(rtab[cand_m]);
  assign e_c   = tgt - $signed(ratio);
  assign mag   = e_c < 0 ? EW'(-e_c) : EW'(e_c);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else begin
      sr[0] <= env_in;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nbq      <= nb;
      cnt      <= '0;
      run      <= 1'b0;
      cur_m    <= lo_of(nb);
      cur_w    <= '0;
      fb       <= '0;
      best_m   <= '0;
      best_w   <= '0;
      best_e   <= '0;
      best_mag <= '0;
    end else begin
      if (searching && (cnt == '0 || mag < best_mag)) begin
        best_m   <= cand_m;
        best_w   <= w_c;
        best_e   <= e_c;
        best_mag <= mag;
      end
      if (cnt == cur_m - 1'b1) begin
        cnt   <= '0;
        cur_m <= best_m;
        cur_w <= best_w;
        fb    <= best_e;
        run   <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign pwm_out   = run && (cnt < cur_w);
  assign pulse_stb = run && (cnt == '0);
  assign pulse_m   = cur_m;
  assign pulse_w   = cur_w;
endmodule

// File: rtl/mqed_pwm_chk.sv
module mqed_pwm_chk #(
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          pwm_out,
  input logic          pulse_stb,
  input logic [PW-1:0] pulse_m,
  input logic [PW-1:0] pulse_w,
  input logic [2:0]    nbq
);
  int lo, hi;
  assign lo = (1 << int'(nbq)) - (1 << (int'(nbq) - 2)) + 1;
  assign hi = (1 << int'(nbq)) + (1 << (int'(nbq) - 2)) - 1;

  a_r1_period_in_range: assert property (@(posedge clk) disable iff (rst)
    pulse_stb |-> (int'(pulse_m) >= lo && int'(pulse_m) <= hi));

  a_r7_width_within_period: assert property (@(posedge clk) disable iff (rst)
    pulse_w <= pulse_m);

  a_r7_leading_edge: assert property (@(posedge clk) disable iff (rst)
    $rose(pwm_out) |-> pulse_stb);

  a_r8_hold_between_strobes: assert property (@(posedge clk) disable iff (rst)
    !pulse_stb |-> ($stable(pulse_m) && $stable(pulse_w)));

  a_r10_zero_width_low: assert property (@(posedge clk) disable iff (rst)
    (pulse_w == '0) |-> !pwm_out);
endmodule

bind mqed_pwm mqed_pwm_chk #(.PW(PW)) u_chk (
  .clk(clk), .rst(rst), .pwm_out(pwm_out), .pulse_stb(pulse_stb),
  .pulse_m(pulse_m), .pulse_w(pulse_w), .nbq(nbq)
);

// File: tb/mqed_pwm_test.sv
`timescale 1ns/100ps
module mqed_pwm_test;
  localparam int LAT = 128;

  typedef struct { int s; int m; int w; } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [11:0] env_in = '0;
  logic [2:0] nb = 3'd6;
  logic       pwm_out, pulse_stb;
  logic [6:0] pulse_m, pulse_w;

  int checks = 0, errors = 0;
  int cyc = 0, cur_mode = 0;
  bit active = 1'b0;
  item_t q[$];
  int hicnt = 0, expw = 0;
  bit fell = 1'b0, shape_bad = 1'b0;

  mqed_pwm uut (
    .clk(clk), .rst(rst), .env_in(env_in), .nb(nb),
    .pwm_out(pwm_out), .pulse_stb(pulse_stb), .pulse_m(pulse_m), .pulse_w(pulse_w)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int gen(input int mode, input int c);
    longint h;
    if (c < 0) return 0;
    case (mode)
      0: return 2048;
      1: return ((c % 512) < 256) ? (c % 512) * 16 : (511 - (c % 512)) * 16;
      2: return 0;
      3: return 4095;
      default: begin
        h = (longint'(c) * 1103515245 + 12345) >>> 8;
        return int'(h & 4095);
      end
    endcase
  endfunction

  // R2 R3 R4 R5: reference search over all periods for a pulse starting at s0
  task automatic decide(input int n, input int s0, input longint fbin,
                        output int bm, output int bw, output longint be);
    int lo, nc;
    longint bmag;
    lo = (1 << n) - (1 << (n - 2)) + 1;
    nc = (1 << (n - 1)) - 1;
    bmag = 0; bm = 0; bw = 0; be = 0;
    for (int s = 0; s < nc; s++) begin
      int m, w;
      longint tgt, wr, r, e, mg;
      m   = lo + s;
      tgt = longint'(gen(cur_mode, s0 + m / 2 - LAT)) * 16 + fbin;
      wr  = (longint'(m) * tgt + 32768) >>> 16;
      if (wr < 0) wr = 0;
      if (wr > m) wr = m;
      w  = int'(wr);
      r  = (65536 + m / 2) / m;
      e  = tgt - longint'(w) * r;
      mg = e < 0 ? -e : e;
      if (s == 0 || mg < bmag) begin
        bmag = mg; bm = m; bw = w; be = e;
      end
    end
  endtask

  task automatic run_phase(input int n, input int mode, input int npulses);
    int s0, lo, bm, bw, s_end;
    longint fbv, be;
    cur_mode = mode;
    lo = (1 << n) - (1 << (n - 2)) + 1;
    s0 = lo; fbv = 0;
    for (int k = 0; k < npulses; k++) begin
      decide(n, s0, fbv, bm, bw, be);
      q.push_back('{s: s0, m: bm, w: bw});
      fbv = be;
      s0 += bm;
    end
    s_end = s0;
    @(negedge clk);
    active = 1'b0;
    rst = 1'b1;
    nb = 3'(n);
    repeat (3) @(negedge clk);
    chk(pwm_out == 1'b0 && pulse_stb == 1'b0, "R9 reset state", {pwm_out, pulse_stb}, 0);
    hicnt = 0; expw = 0; fell = 1'b0; shape_bad = 1'b0;
    rst = 1'b0;
    cyc = 0;
    env_in = 12'(gen(mode, 0));
    active = 1'b1;
    while (cyc <= s_end + 1) begin
      @(negedge clk);
      cyc = cyc + 1;
      env_in = 12'(gen(mode, cyc));
    end
    active = 1'b0;
    chk(q.size() == 0, "R8 every expected strobe seen", q.size(), 0);
    q.delete();
  endtask

  // monitor: samples 1 ns after each rising edge
  always @(posedge clk) begin
    #1;
    if (active) begin
      int c;
      c = cyc + 1;
      if (pulse_stb) begin
        chk(hicnt == expw && !shape_bad, "R7 R10 high time and shape of previous pulse", hicnt, expw);
        if (q.size() > 0) begin
          item_t it;
          it = q.pop_front();
          chk(c == it.s, "R9 R8 strobe clock", c, it.s);
          chk(int'(pulse_m) == it.m, "R1 R2 R5 R6 chosen period", pulse_m, it.m);
          chk(int'(pulse_w) == it.w, "R3 R4 chosen width", pulse_w, it.w);
          expw = it.w;
        end
        hicnt = 0; fell = 1'b0; shape_bad = 1'b0;
      end
      if (pwm_out) begin
        if (fell) shape_bad = 1'b1;
        hicnt++;
      end else if (hicnt > 0) begin
        fell = 1'b1;
      end
    end
  end

  initial begin
    #(5.0 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    run_phase(6, 0, 20);
    run_phase(6, 1, 40);
    run_phase(6, 2, 8);
    run_phase(6, 3, 8);
    run_phase(4, 4, 60);
    run_phase(4, 1, 40);
    run_phase(6, 4, 30);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule